// File: doc/BRIEF.md
# Predicated Vector Element Loop Sequencer

This block is a hardware loop that expands one ALU operation, written with ordinary scalar register numbers, into a series of per-element additions on a standard integer register file. A start pulse captures a destination register, two source registers, the number of the register that holds the predicate, a global vector length, the vector length recorded for the destination, and a bit vector that marks which registers are vectorised. The loop then handles one element per clock. It drives the two source read addresses, adds the read data, and writes the sum to the destination index whenever the element's predicate bit is set.

Each operand index moves forward by one per element only when that register is tagged as vectorised. Any tagged operand therefore walks through consecutive registers, and any untagged operand stays fixed. The same loop covers scalar-scalar, scalar-vector and vector-vector forms. An element whose predicate bit is clear still uses its cycle, but nothing is written. Its destination keeps its old contents instead of being zeroed. A busy flag covers the loop, and a one-cycle done pulse follows it.

Top module: `vec_elem_seq`

## Requirements
- R1: The element count is the smaller of the global length and the destination length, limited to XLEN. A request of 40 against 63 with XLEN=32 runs exactly 32 elements.
- R2: The predicate is read from the integer register named by the predicate number, during the start cycle. Bit i enables element i (bit 0 is element 0). A clear bit produces no write, and the destination register keeps its previous value.
- R3: The write address is destination + i (modulo the register count) when the destination is tagged vectorised, and the fixed destination number when it is not.
- R4: Each source read address is its base + i (modulo the register count) when that source is tagged, and the fixed base when it is not. The two sources step independently.
- R5: Every element takes exactly one cycle, including skipped elements. Busy stays high for exactly count cycles, and at most one write occurs per cycle.
- R6: A start is accepted only while the block is not busy. Operands and predicate are latched at acceptance. Input changes, extra starts, and writes to the predicate register during the loop do not alter the running sequence.
- R7: Done is high for one cycle, in the cycle after the last element, with busy low. A new start is accepted in that cycle.
- R8: A count of zero gives no busy cycle and no write, and done is high in the cycle after the start.
- R9: After reset, busy, done and the write enable are low.
- R10: The write data is the sum of the two read values modulo 2^XLEN. A read that follows a write within the same loop sees the written value.
- R11: A vector tag bit selects per register number (bit k tags register k). Only the tags of the three named registers, captured at start, affect the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request |
| dst_i | input | $clog2(NREG) | Destination register number |
| src1_i | input | $clog2(NREG) | First source register number |
| src2_i | input | $clog2(NREG) | Second source register number |
| pred_i | input | $clog2(NREG) | Register holding the predicate mask |
| gvl_i | input | $clog2(XLEN+1) | Global vector length |
| dvl_i | input | $clog2(XLEN+1) | Vector length recorded for the destination |
| vtag_i | input | NREG | Vectorised tag per register |
| pred_addr_o | output | $clog2(NREG) | Predicate read address |
| pred_data_i | input | XLEN | Predicate read data |
| rd1_addr_o | output | $clog2(NREG) | First source read address |
| rd1_data_i | input | XLEN | First source read data |
| rd2_addr_o | output | $clog2(NREG) | Second source read address |
| rd2_data_i | input | XLEN | Second source read data |
| wr_en_o | output | 1 | Register write enable |
| wr_addr_o | output | $clog2(NREG) | Register write address |
| wr_data_o | output | XLEN | Register write data |
| busy_o | output | 1 | Loop in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets several corner cases:
- Length clamping. A design that ignores the XLEN cap, or picks the larger length, would run too many elements.
- A length of zero. A faulty design would stick in busy or emit a stray write.
- An all-clear predicate. A design that skips masked cycles instead of stepping through them would end the loop early.
- A zeroing design would write to masked elements.
- A loop whose destination overwrites the predicate register. A design that rereads the mask each cycle would change which elements are written.
- Index wrap past the last register, a scalar destination receiving repeated writes, and a source that stays fixed while the other advances. A design that steps an untagged operand would address the wrong register.
- A start during the loop and a start in the done cycle. These show whether acceptance is gated on busy and nothing else.

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG),
  localparam int VLW = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   dst_i,
  input  logic [AW-1:0]   src1_i,
  input  logic [AW-1:0]   src2_i,
  input  logic [AW-1:0]   pred_i,
  input  logic [VLW-1:0]  gvl_i,
  input  logic [VLW-1:0]  dvl_i,
  input  logic [NREG-1:0] vtag_i,
  output logic [AW-1:0]   pred_addr_o,
  input  logic [XLEN-1:0] pred_data_i,
  output logic [AW-1:0]   rd1_addr_o,
  input  logic [XLEN-1:0] rd1_data_i,
  output logic [AW-1:0]   rd2_addr_o,
  input  logic [XLEN-1:0] rd2_data_i,
  output logic            wr_en_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [XLEN-1:0] wr_data_o,
  output logic            busy_o,
  output logic            done_o
);

  localparam logic [VLW-1:0] VL_MAX = VLW'(XLEN);

  logic            busy_q, done_q;
  logic [VLW-1:0]  idx_q, cnt_q;
  logic [AW-1:0]   dst_q, s1_q, s2_q;
  logic            vd_q, v1_q, v2_q;
  logic [XLEN-1:0] mask_q;
  logic [VLW-1:0]  vl_min, vl_eff;
  logic [AW-1:0]   step;
  logic            last;

  assign vl_min = (gvl_i < dvl_i) ? gvl_i : dvl_i;
  assign vl_eff = (vl_min > VL_MAX) ? VL_MAX : vl_min;
  assign step   = AW'(idx_q);
  assign last   = (idx_q == cnt_q - VLW'(1));

  assign pred_addr_o = pred_i;
  assign rd1_addr_o  = s1_q + (v1_q ? step : '0);
  assign rd2_addr_o  = s2_q + (v2_q ? step : '0);
  assign wr_addr_o   = dst_q + (vd_q ? step : '0);
  assign wr_data_o   = rd1_data_i + rd2_data_i;
  assign wr_en_o     = busy_q & mask_q[0];
  assign busy_o      = busy_q;
  assign done_o      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      dst_q  <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      vd_q   <= 1'b0;
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      mask_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          dst_q  <= dst_i;
          s1_q   <= src1_i;
          s2_q   <= src2_i;
          vd_q   <= vtag_i[dst_i];
          v1_q   <= vtag_i[src1_i];
          v2_q   <= vtag_i[src2_i];
          mask_q <= pred_data_i;
          cnt_q  <= vl_eff;
          idx_q  <= '0;
          if (vl_eff == '0) done_q <= 1'b1;
          else              busy_q <= 1'b1;
        end
      end else begin
        idx_q  <= idx_q + VLW'(1);
        mask_q <= mask_q >> 1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  p_idx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (idx_q < cnt_q) && (cnt_q <= VL_MAX));

  p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> idx_q == $past(idx_q) + VLW'(1));

  p_scalar_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) && !vd_q |-> wr_addr_o == $past(wr_addr_o));

  p_done_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && (vl_eff == '0) |=> done_o && !busy_o && !wr_en_o);

  p_busy_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(dst_q) && $stable(s1_q) && $stable(s2_q));

endmodule

// File: tb/tb_vec_elem_seq.sv
module tb_vec_elem_seq;
  localparam int XLEN = 32;
  localparam int NREG = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start_i = 1'b0;
  logic [4:0]  dst_i = '0, src1_i = '0, src2_i = '0, pred_i = '0;
  logic [5:0]  gvl_i = '0, dvl_i = '0;
  logic [31:0] vtag_i = '0;
  logic [4:0]  pred_addr_o, rd1_addr_o, rd2_addr_o, wr_addr_o;
  logic [31:0] pred_data_i, rd1_data_i, rd2_data_i, wr_data_o;
  logic        wr_en_o, busy_o, done_o;

  vec_elem_seq #(.XLEN(XLEN), .NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dst_i(dst_i), .src1_i(src1_i), .src2_i(src2_i), .pred_i(pred_i),
    .gvl_i(gvl_i), .dvl_i(dvl_i), .vtag_i(vtag_i),
    .pred_addr_o(pred_addr_o), .pred_data_i(pred_data_i),
    .rd1_addr_o(rd1_addr_o), .rd1_data_i(rd1_data_i),
    .rd2_addr_o(rd2_addr_o), .rd2_data_i(rd2_data_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  function automatic logic [31:0] initv(int k);
    if (k == 31) return 32'hFFFF_FFFF;
    if (k == 30) return 32'h0;
    return k * 32'h9E37_79B9 + 32'h0F1E_2D3C;
  endfunction

  logic [31:0] rf [NREG];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) rf[k] <= initv(k);
    end else if (wr_en_o) rf[wr_addr_o] <= wr_data_o;
  end
  assign pred_data_i = rf[pred_addr_o];
  assign rd1_data_i  = rf[rd1_addr_o];
  assign rd2_data_i  = rf[rd2_addr_o];

  typedef struct { logic busy, done, we; logic [4:0] wa; logic [31:0] wd; } exp_t;
  exp_t q[$];
  logic [31:0] mdl [NREG];
  logic last_busy = 1'b0;
  int tests = 0, fails = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else e = '{busy: 1'b0, done: 1'b0, we: 1'b0, wa: '0, wd: '0};
    chk("R5 busy", 32'(busy_o), 32'(e.busy));
    chk("R7 done", 32'(done_o), 32'(e.done));
    chk("R2 write enable", 32'(wr_en_o), 32'(e.we));
    if (e.we) begin
      chk("R3 write address", 32'(wr_addr_o), 32'(e.wa));
      chk("R10 write data", wr_data_o, e.wd);
    end
    last_busy = e.busy;
  endtask

  // Reference: R1 count, R2 mask captured up front, R3/R4/R11 stepping, R10 sums
  task automatic push_op(int d, int s1, int s2, int p, int g, int dv, logic [31:0] tg);
    int cnt;
    logic [31:0] mask;
    cnt  = (g < dv) ? g : dv;
    if (cnt > XLEN) cnt = XLEN;
    mask = mdl[p];
    for (int i = 0; i < cnt; i++) begin
      exp_t e;
      int ra, rb, wa;
      ra = (s1 + (tg[s1] ? i : 0)) % NREG;
      rb = (s2 + (tg[s2] ? i : 0)) % NREG;
      wa = (d  + (tg[d]  ? i : 0)) % NREG;
      e.busy = 1'b1; e.done = 1'b0; e.we = mask[i];
      e.wa = 5'(wa); e.wd = mdl[ra] + mdl[rb];
      if (e.we) mdl[wa] = e.wd;
      q.push_back(e);
    end
    q.push_back('{busy: 1'b0, done: 1'b1, we: 1'b0, wa: '0, wd: '0});
  endtask

  task automatic launch(int d, int s1, int s2, int p, int g, int dv, logic [31:0] tg);
    dst_i = 5'(d); src1_i = 5'(s1); src2_i = 5'(s2); pred_i = 5'(p);
    gvl_i = 6'(g); dvl_i = 6'(dv); vtag_i = tg; start_i = 1'b1;
    if (!last_busy) push_op(d, s1, s2, p, g, dv, tg);
    cyc();
    start_i = 1'b0;
    // R6: scramble inputs while the loop runs
    dst_i = ~dst_i; src1_i = ~src1_i; src2_i = ~src2_i; pred_i = 5'd30;
    gvl_i = 6'd1; dvl_i = 6'd1; vtag_i = ~vtag_i;
  endtask

  task automatic drain();
    while (q.size() > 0) cyc();
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) mdl[k] = initv(k);
    repeat (3) cyc();
    // R9: reset state
    chk("R9 reset busy", 32'(busy_o), 0);
    chk("R9 reset done", 32'(done_o), 0);
    chk("R9 reset we", 32'(wr_en_o), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc();
    // vector-vector, all enabled
    launch(10, 0, 5, 31, 8, 8, 32'hFFFF_FFFF); drain(); cyc();
    // R3: scalar destination receives repeated writes
    launch(12, 1, 2, 31, 4, 4, ~(32'h1 << 12)); drain(); cyc();
    // R4: scalar first source, vector second source
    launch(20, 3, 24, 31, 5, 5, ~(32'h1 << 3)); drain(); cyc();
    // R2: mixed predicate pattern from register 7
    launch(14, 16, 22, 7, 12, 12, 32'hFFFF_FFFF); drain(); cyc();
    // R1: global length smaller, then destination length smaller
    launch(2, 6, 9, 31, 3, 6, 32'hFFFF_FFFF); drain(); cyc();
    launch(2, 6, 9, 31, 6, 2, 32'hFFFF_FFFF); drain(); cyc();
    // R8: zero length
    launch(4, 4, 4, 31, 0, 9, 32'hFFFF_FFFF); drain(); cyc();
    // R2/R5: all-clear predicate still spends every cycle
    launch(8, 9, 10, 30, 7, 7, 32'hFFFF_FFFF); drain(); cyc();
    // R6: start during the loop is ignored
    launch(24, 25, 26, 31, 4, 4, 32'hFFFF_FFFF);
    launch(1, 1, 1, 31, 3, 3, 32'hFFFF_FFFF); drain(); cyc();
    // R1/R3/R4: clamp to XLEN and index wrap
    launch(20, 3, 17, 31, 40, 63, 32'hFFFF_FFFF); drain(); cyc();
    // R6: loop overwrites its own predicate register
    launch(3, 11, 13, 5, 6, 6, 32'hFFFF_FFFF); drain();
    // R7: new start accepted in the done cycle; R11 tags only on named regs
    launch(18, 19, 27, 31, 3, 3, 32'h0804_0000); drain();
    launch(6, 6, 6, 31, 2, 2, 32'h0000_0040); drain(); cyc(); cyc();
    for (int k = 0; k < NREG; k++) chk("R2 register contents", rf[k], mdl[k]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule